// File: doc/BRIEF.md
# System Bus Region Decoder with Per-Size Wait States

This block sits between a single processor-style bus master and eight memory regions. The master presents a request strobe together with a 32-bit address, a direction flag, an access size and write data. When the block is idle it accepts the request and latches all of these. It then decodes the address to a one-hot region select and drives a 24-bit offset to the slaves. It counts out a latency that depends on both the region and the access size. On the final cycle it pulses `done_o`, returns the selected region's read data, and for writes raises a one-cycle write strobe.

An address that falls in no region is never routed. It finishes one cycle after acceptance with `err_o` high, no region select and no write strobe. Latencies come from a packed parameter table indexed by region and size class. By default, word accesses to palette RAM and video RAM take two cycles and every other access takes one.

Top module: `sysbus_region_dec`

## Requirements
- R1: Regions are numbered 0 to 7, and `sel_o` bit i selects region i. The ranges are: 0x0000_0000–0x0000_3FFF is region 0 (boot ROM), 0x0200_0000–0x0203_FFFF is region 1 (external work RAM), 0x0300_0000–0x0300_7FFF is region 2 (internal work RAM), 0x0500_0000–0x0500_03FF is region 4 (palette), 0x0600_0000–0x0601_7FFF is region 5 (video RAM), 0x0700_0000–0x0700_03FF is region 6 (object attributes) and 0x0800_0000–0x09FF_FFFF is region 7 (cartridge). `sel_o` is one-hot while a mapped access is in flight and zero otherwise.
- R2: Region 3 (I/O registers) covers 0x0400_0000–0x0400_03FE. The address 0x0400_03FF is unmapped.
- R3: An unmapped address completes exactly 1 cycle after acceptance with `err_o` high for one cycle, `done_o` low, `sel_o` zero and `wr_o` low.
- R4: While a mapped access is in flight, `offs_o` equals the accepted address ANDed with 0x00FF_FFFF.
- R5: Size is encoded as 0 = byte, 1 = halfword, 2 = word. Regions 4 and 5 complete 1 cycle after acceptance for byte and halfword accesses and 2 cycles after acceptance for word accesses.
- R6: All other regions complete 1 cycle after acceptance for every size. Size code 3 is timed as a word.
- R7: `done_o` is high for exactly one cycle per mapped access. In that cycle `rdata_o` equals the 32-bit slice of `rdata_i` belonging to the selected region (bits 32i+31:32i for region i).
- R8: `wr_o` is high only in the completing cycle of a mapped write, and `wdata_o` then carries the accepted write data.
- R9: A request that arrives while an access is in flight is ignored. Address, direction and data of the current access do not change.
- R10: After reset `sel_o`, `done_o`, `err_o` and `wr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe from the master |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size code |
| addr_i | input | 32 | Request address |
| wdata_i | input | 32 | Write data |
| rdata_i | input | 256 | Read data from the eight regions, region i in bits 32i+31:32i |
| sel_o | output | 8 | One-hot region select |
| offs_o | output | 24 | Region offset |
| size_o | output | 2 | Latched access size to the slaves |
| wdata_o | output | 32 | Latched write data |
| wr_o | output | 1 | Write strobe on the completing cycle |
| done_o | output | 1 | Completion pulse for a mapped access |
| err_o | output | 1 | Completion pulse for an unmapped access |
| rdata_o | output | 32 | Read data returned in the done cycle |

## Verification
The bench probes the first and last address of every region and the address just past each one. This includes the odd I/O limit at 0x0400_03FE/0x0400_03FF, where an off-by-one decoder would select region 3 instead of faulting. It runs every region with every size code. A table indexed wrongly, or a missing size-3 mapping, shows up as `done_o` arriving one cycle early or late. A second request is raised in mid-flight. A design that re-accepts while busy would change `offs_o` or `wdata_o` before completion. Write accesses check that the strobe appears only in the final cycle, and unmapped accesses check that no select or strobe leaks out with the error.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
  localparam int NREG   = 8;
  localparam int NSIZE  = 3;
  localparam int IDX_W  = $clog2(NREG);
  localparam int WAIT_W = 4;
  localparam int TBL_W  = NREG * NSIZE * WAIT_W;

  localparam int RG_PAL  = 4;
  localparam int RG_VRAM = 5;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_X = 2'd3} size_e;

  localparam logic [31:0] REG_BASE [NREG] = '{
    32'h0000_0000, 32'h0200_0000, 32'h0300_0000, 32'h0400_0000,
    32'h0500_0000, 32'h0600_0000, 32'h0700_0000, 32'h0800_0000};
  localparam logic [31:0] REG_LAST [NREG] = '{
    32'h0000_3FFF, 32'h0203_FFFF, 32'h0300_7FFF, 32'h0400_03FE,
    32'h0500_03FF, 32'h0601_7FFF, 32'h0700_03FF, 32'h09FF_FFFF};

  // size code -> table column; the spare code is timed as a word
  function automatic int unsigned size_class(input logic [1:0] s);
    case (s)
      SZ_B:    return 0;
      SZ_H:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [TBL_W-1:0] default_waits();
    logic [TBL_W-1:0] t;
    t = '0;
    for (int r = 0; r < NREG; r++)
      for (int s = 0; s < NSIZE; s++)
        t[(r*NSIZE+s)*WAIT_W +: WAIT_W] =
          ((r == RG_PAL || r == RG_VRAM) && s == 2) ? WAIT_W'(2) : WAIT_W'(1);
    return t;
  endfunction
endpackage

// File: rtl/bus_map_decode.sv
module bus_map_decode
  import sysbus_pkg::*;
(
  input  logic [31:0]      addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NREG-1:0] match;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match[g] = (addr_i >= REG_BASE[g]) && (addr_i <= REG_LAST[g]);
  end

  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = 0; i < NREG; i++)
      if (match[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/bus_wait_timer.sv
module bus_wait_timer
  import sysbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] load_i,
  output logic              busy_o,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (start_i && !busy_o)  cnt_q <= (load_i == '0) ? WAIT_W'(1) : load_i;
    else if (busy_o)              cnt_q <= cnt_q - WAIT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == WAIT_W'(1));

  // R5/R6: a started access stays busy until its last cycle
  a_r5_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o) |=> busy_o);
  // R6: last cycle always frees the timer
  a_r6_last_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !busy_o);
endmodule

// File: rtl/sysbus_region_dec.sv
module sysbus_region_dec
  import sysbus_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              OFFS_W   = 24,
  parameter logic [TBL_W-1:0] WAIT_TBL = default_waits()
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [1:0]             size_i,
  input  logic [31:0]            addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [NREG*DATA_W-1:0] rdata_i,
  output logic [NREG-1:0]        sel_o,
  output logic [OFFS_W-1:0]      offs_o,
  output logic [1:0]             size_o,
  output logic [DATA_W-1:0]      wdata_o,
  output logic                   wr_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [DATA_W-1:0]      rdata_o
);
  logic             hit, busy, last, accept;
  logic [IDX_W-1:0] idx;
  logic [WAIT_W-1:0] wait_n;

  logic [31:0]       addr_q;
  logic              we_q, hit_q;
  logic [1:0]        size_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] wdata_q;

  bus_map_decode u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  always_comb begin
    if (hit) wait_n = WAIT_TBL[(int'(idx)*NSIZE + int'(size_class(size_i)))*WAIT_W +: WAIT_W];
    else     wait_n = WAIT_W'(1);
  end

  assign accept = req_i && !busy;

  bus_wait_timer u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .load_i  (wait_n),
    .busy_o  (busy),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
      size_q  <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= addr_i;
      we_q    <= we_i;
      hit_q   <= hit;
      size_q  <= size_i;
      idx_q   <= idx;
      wdata_q <= wdata_i;
    end
  end

  always_comb begin
    sel_o = '0;
    if (busy && hit_q) sel_o[idx_q] = 1'b1;
  end

  assign offs_o  = addr_q[OFFS_W-1:0];
  assign size_o  = size_q;
  assign wdata_o = wdata_q;
  assign done_o  = last && hit_q;
  assign err_o   = last && !hit_q;
  assign wr_o    = done_o && we_q;
  assign rdata_o = done_o ? rdata_i[int'(idx_q)*DATA_W +: DATA_W] : '0;

  a_r1_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  a_r3_err_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sel_o == '0 && !wr_o && !done_o));
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_wr_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (done_o && $countones(sel_o) == 1));
  a_r9_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last) |=> ($stable(addr_q) && $stable(wdata_q) && $stable(we_q)));
endmodule

// File: tb/sim_sysbus_region_dec.sv
module sim_sysbus_region_dec;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [1:0]   size = 2'd0;
  logic [31:0]  addr = '0, wdata = '0;
  logic [255:0] rdata_i;
  logic [7:0]   sel_o;
  logic [23:0]  offs_o;
  logic [1:0]   size_o;
  logic [31:0]  wdata_o, rdata_o;
  logic         wr_o, done_o, err_o;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sysbus_region_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_i(rdata_i), .sel_o(sel_o),
    .offs_o(offs_o), .size_o(size_o), .wdata_o(wdata_o), .wr_o(wr_o),
    .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  // slave model: each region answers with its tag and the offset it sees
  always_comb
    for (int r = 0; r < 8; r++) rdata_i[r*32 +: 32] = {8'(8'hC0 + r), offs_o};

  function automatic int exp_region(input logic [31:0] a);
    if (a <= 32'h0000_3FFF) return 0;
    if (a >= 32'h0200_0000 && a <= 32'h0203_FFFF) return 1;
    if (a >= 32'h0300_0000 && a <= 32'h0300_7FFF) return 2;
    if (a >= 32'h0400_0000 && a <= 32'h0400_03FE) return 3;
    if (a >= 32'h0500_0000 && a <= 32'h0500_03FF) return 4;
    if (a >= 32'h0600_0000 && a <= 32'h0601_7FFF) return 5;
    if (a >= 32'h0700_0000 && a <= 32'h0700_03FF) return 6;
    if (a >= 32'h0800_0000 && a <= 32'h09FF_FFFF) return 7;
    return -1;
  endfunction

  function automatic int exp_wait(input int r, input logic [1:0] sz);
    if (r < 0) return 1;
    if ((r == 4 || r == 5) && sz >= 2'd2) return 2;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s t=%0t actual=%0h expected=%0h", tag, what, $time, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [1:0] sz,
                        input logic [31:0] wd, input bit poke, input string tag);
    int r, n;
    r = exp_region(a);
    n = exp_wait(r, sz);
    @(negedge clk);
    req = 1'b1; addr = a; we = w; size = sz; wdata = wd;
    @(negedge clk);
    if (poke) begin
      req = 1'b1; addr = 32'h0300_0010; we = ~w; wdata = ~wd; // R9 intruder
    end else req = 1'b0;
    for (int c = 1; c <= n + 1; c++) begin
      logic [7:0] es;
      bit fin, act;
      if (c > 1) @(negedge clk);
      if (c == 2) req = 1'b0;
      fin = (c == n);
      act = (c <= n);
      es  = (act && r >= 0) ? 8'(1 << r) : 8'h00;
      chk(sel_o == es, tag, "sel", 64'(sel_o), 64'(es));
      chk(done_o == (fin && r >= 0), tag, "done", 64'(done_o), 64'(fin && r >= 0));
      chk(err_o == (fin && r < 0), tag, "err", 64'(err_o), 64'(fin && r < 0));
      chk(wr_o == (fin && r >= 0 && w), tag, "wr", 64'(wr_o), 64'(fin && r >= 0 && w));
      if (act && r >= 0)
        chk(offs_o == a[23:0], tag, "offs R4", 64'(offs_o), 64'(a[23:0]));
      if (fin && r >= 0 && w)
        chk(wdata_o == wd, tag, "wdata R8", 64'(wdata_o), 64'(wd));
      if (fin && r >= 0 && !w)
        chk(rdata_o == {8'(8'hC0 + r), a[23:0]}, tag, "rdata R7",
            64'(rdata_o), 64'({8'(8'hC0 + r), a[23:0]}));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] lo [8] = '{32'h0000_0000, 32'h0200_0000, 32'h0300_0000, 32'h0400_0000,
                          32'h0500_0000, 32'h0600_0000, 32'h0700_0000, 32'h0800_0000};
  logic [31:0] hi [8] = '{32'h0000_3FFF, 32'h0203_FFFF, 32'h0300_7FFF, 32'h0400_03FE,
                          32'h0500_03FF, 32'h0601_7FFF, 32'h0700_03FF, 32'h09FF_FFFF};

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(sel_o == 8'h00 && !done_o && !err_o && !wr_o, "R10", "reset outputs",
        64'({sel_o, done_o, err_o, wr_o}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_o == 8'h00 && !done_o && !err_o && !wr_o, "R10", "idle outputs",
        64'({sel_o, done_o, err_o, wr_o}), 64'h0);

    // R1, R5, R6, R7: every region, every size code, both ends of the range
    for (int r = 0; r < 8; r++)
      for (int s = 0; s < 4; s++) begin
        access(lo[r], 1'b0, 2'(s), 32'h0, 1'b0, (r == 4 || r == 5) ? "R5" : "R6");
        access(hi[r], 1'b0, 2'(s), 32'h0, 1'b0, "R1");
      end

    // R2: I/O upper edge
    access(32'h0400_03FE, 1'b0, 2'd1, 32'h0, 1'b0, "R2");
    access(32'h0400_03FF, 1'b0, 2'd1, 32'h0, 1'b0, "R2");

    // R3: unmapped gaps and the address just past each region
    for (int r = 0; r < 8; r++)
      access(hi[r] + 32'd1, 1'b1, 2'd2, 32'h1234_5678, 1'b0, "R3");
    access(32'h0100_0000, 1'b0, 2'd0, 32'h0, 1'b0, "R3");
    access(32'hFFFF_FFFF, 1'b1, 2'd2, 32'hDEAD_BEEF, 1'b0, "R3");

    // R4: offset masking on upper cartridge range
    access(32'h09AB_CDEF, 1'b0, 2'd2, 32'h0, 1'b0, "R4");

    // R8: writes of several sizes
    access(32'h0601_0004, 1'b1, 2'd2, 32'hCAFE_F00D, 1'b0, "R8");
    access(32'h0300_0123, 1'b1, 2'd0, 32'h0000_00A5, 1'b0, "R8");
    access(32'h0500_0002, 1'b1, 2'd1, 32'h0000_5A5A, 1'b0, "R8");

    // R9: requests raised mid-flight are ignored
    access(32'h0600_0100, 1'b1, 2'd2, 32'h0BAD_F00D, 1'b1, "R9");
    access(32'h0500_0200, 1'b0, 2'd2, 32'h0, 1'b1, "R9");
    access(32'h0200_0040, 1'b0, 2'd0, 32'h0, 1'b1, "R9");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule